// File: doc/BRIEF.md
# Translation Root Register with Mode Gating

This block is the supervisor control register that tells a 64-bit core's address translation where to start. It holds three fields: a 4-bit translation mode, a 16-bit address-space identifier and the 44-bit physical page number of the root page table. A control-register write port loads all three fields together. The full 64-bit value can be read back, and decoded copies of each field go straight to the translation logic. A single flag reports whether paged translation is active.

The implementation chooses which modes it supports with a 16-bit parameter. Bit n of the parameter stands for mode value n. Bare mode is always supported. Only the 39-bit and 48-bit paged modes can be added to it. If a write carries a mode that is not in the supported set, the whole write is dropped and the ASID and PPN fields keep their old values as well. Privilege checks, control-register address decoding and translation-cache flushes are handled by the surrounding logic.

Top module: `xlat_root_reg`

## Requirements
- R1: While reset is held low at a rising edge, the register clears to all zeros. This is bare mode with ASID 0 and PPN 0.
- R2: The register layout is fixed. The mode is in bits 63:60, the ASID in bits 59:44 and the root PPN in bits 43:0. `mode_o`, `asid_o` and `root_ppn_o` always equal those slices of `rd_data`.
- R3: A write whose mode is supported replaces all 64 bits. The new value is visible on `rd_data` after the rising edge that samples `wr_en` high.
- R4: A write whose mode is a paged mode (8 = 39-bit, 9 = 48-bit) that the parameter leaves out has no effect. No field changes.
- R5: Mode 0 (bare) is accepted even when bit 0 of `SUPPORTED_MODES` is clear.
- R6: Mode values 1 to 7 and 10 to 15 are never accepted, whatever the parameter says. A write carrying one of them changes no field.
- R7: An accepted write in bare mode still stores the written ASID and PPN.
- R8: `xlat_on_o` is high exactly when the stored mode is nonzero. The stored mode is then always 8 or 9.
- R9: With `wr_en` low, the register holds its value whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control-register port |
| wr_data | input | 64 | Value offered for the write |
| rd_data | output | 64 | Stored register value |
| mode_o | output | 4 | Stored translation mode |
| asid_o | output | 16 | Stored address-space identifier |
| root_ppn_o | output | 44 | Stored root page-table PPN |
| xlat_on_o | output | 1 | Paged translation active |

## Verification
A wrong acceptance decision shows on `rd_data` at the first falling edge after the write edge. Either an illegal mode appears in the register, or a legal write fails to replace the ASID and PPN. Every later read keeps showing the same wrong value until the next accepted write. The bench uses three parameter settings: the default, bare only, and every bit set. It sweeps all sixteen mode values against several ASID and PPN patterns, and before each sweep it loads a nonzero paged state so that a dropped write stays visible. An incorrect field slice or enable flag shows on the decoded outputs in the same cycle as the stored value.

// File: rtl/xlat_root_pkg.sv
// Shared widths, field layout and mode codes for the translation root register.
// Assumes a 64-bit register: the field widths must add up to XLEN.
package xlat_root_pkg;
    localparam int XLEN   = 64;
    localparam int MODE_W = 4;
    localparam int ASID_W = 16;
    localparam int PPN_W  = XLEN - MODE_W - ASID_W;
    localparam int NMODES = 1 << MODE_W;

    // Mode codes that carry behaviour in this block.
    localparam logic [MODE_W-1:0] MODE_BARE  = 4'd0;
    localparam logic [MODE_W-1:0] MODE_PG39  = 4'd8;
    localparam logic [MODE_W-1:0] MODE_PG48  = 4'd9;

    // Modes that may ever be enabled: bare plus the two paged schemes.
    localparam logic [NMODES-1:0] DEFINED_MASK =
        (NMODES'(1) << MODE_BARE) | (NMODES'(1) << MODE_PG39) | (NMODES'(1) << MODE_PG48);

    // Register image; the first member lands in the top bits.
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
    } root_fields_t;
endpackage

// File: rtl/xlat_mode_filter.sv
// Decides whether a mode code on the write bus may be stored.
// Assumes SUPPORTED holds one bit per mode code; bits outside the defined
// set are ignored and bare mode is forced on.
module xlat_mode_filter
    import xlat_root_pkg::*;
#(
    parameter logic [NMODES-1:0] SUPPORTED = DEFINED_MASK
) (
    input  logic [MODE_W-1:0] mode_i,
    output logic              accept_o
);
    localparam logic [NMODES-1:0] EFFECTIVE =
        (SUPPORTED & DEFINED_MASK) | (NMODES'(1) << MODE_BARE);

    logic [NMODES-1:0] hit;

    // One comparator per mode code, kept only where the mode is enabled.
    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        if (EFFECTIVE[m]) begin : g_on
            assign hit[m] = (mode_i == MODE_W'(m));
        end else begin : g_off
            assign hit[m] = 1'b0;
        end
    end

    // Accept when any enabled code matches.
    always_comb accept_o = |hit;
endmodule

// File: rtl/xlat_root_store.sv
// Holds the 64-bit register image. It loads the whole image on a qualified
// write and clears it on synchronous active-low reset.
// Assumes the caller has already gated load_i with the legality decision.
module xlat_root_store
    import xlat_root_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  root_fields_t d_i,
    output root_fields_t q_o
);
    root_fields_t q;

    // State register: clear on reset, load the full image on a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_i) begin
            q <= d_i;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/xlat_root_reg.sv
// Top of the translation root register. It checks the mode on each write,
// stores the full image only when that mode is supported, and decodes the
// stored fields for the translation logic.
// Assumes privilege and address decode are resolved before wr_en is raised.
module xlat_root_reg
    import xlat_root_pkg::*;
#(
    parameter logic [15:0] SUPPORTED_MODES = 16'h0301
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic [3:0]  mode_o,
    output logic [15:0] asid_o,
    output logic [43:0] root_ppn_o,
    output logic        xlat_on_o
);
    root_fields_t wr_img;
    root_fields_t cur;
    logic         mode_ok;
    logic         load;

    assign wr_img = root_fields_t'(wr_data);

    xlat_mode_filter #(.SUPPORTED(SUPPORTED_MODES)) u_filter (
        .mode_i   (wr_img.mode),
        .accept_o (mode_ok)
    );

    // Qualify the write: an unsupported mode drops every field.
    always_comb load = wr_en && mode_ok;

    xlat_root_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    (wr_img),
        .q_o    (cur)
    );

    // Decode the stored image onto the output ports.
    always_comb begin
        rd_data    = cur;
        mode_o     = cur.mode;
        asid_o     = cur.asid;
        root_ppn_o = cur.ppn;
        xlat_on_o  = (cur.mode != MODE_BARE);
    end
endmodule

// File: rtl/xlat_root_chk.sv
// Property checker for xlat_root_reg, attached through the bind below.
// Assumes the same SUPPORTED_MODES value as the bound instance.
module xlat_root_chk #(
    parameter logic [15:0] SUPPORTED_MODES = 16'h0301
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [63:0] rd_data,
    input logic [3:0]  mode_o,
    input logic [15:0] asid_o,
    input logic [43:0] root_ppn_o,
    input logic        xlat_on_o
);
    localparam logic [15:0] LEGAL = (SUPPORTED_MODES & 16'h0301) | 16'h0001;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> rd_data == 64'd0);

    assert_field_slices_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == {mode_o, asid_o, root_ppn_o});

    assert_accept_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && LEGAL[wr_data[63:60]] |=> rd_data == $past(wr_data));

    assert_reject_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !LEGAL[wr_data[63:60]] |=> $stable(rd_data));

    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        LEGAL[mode_o]);

    assert_on_is_paged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_on_o |-> (mode_o == 4'd8 || mode_o == 4'd9));

    assert_off_is_bare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_on_o |-> mode_o == 4'd0);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

bind xlat_root_reg xlat_root_chk #(.SUPPORTED_MODES(SUPPORTED_MODES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .mode_o     (mode_o),
    .asid_o     (asid_o),
    .root_ppn_o (root_ppn_o),
    .xlat_on_o  (xlat_on_o)
);

// File: tb/xlat_root_reg_tb.sv
// Sweeps every mode code against several payloads on three parameter settings.
module xlat_root_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CFG_DEF  = 16'h0301;
    localparam logic [15:0] CFG_BARE = 16'h0000;
    localparam logic [15:0] CFG_ALL  = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;

    logic [63:0] rd [3];
    logic [3:0]  md [3];
    logic [15:0] as [3];
    logic [43:0] pp [3];
    logic        on [3];
    logic [63:0] exp_q [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_root_reg #(.SUPPORTED_MODES(CFG_DEF)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[0]), .mode_o(md[0]), .asid_o(as[0]), .root_ppn_o(pp[0]), .xlat_on_o(on[0]));
    xlat_root_reg #(.SUPPORTED_MODES(CFG_BARE)) u_dut_bare (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[1]), .mode_o(md[1]), .asid_o(as[1]), .root_ppn_o(pp[1]), .xlat_on_o(on[1]));
    xlat_root_reg #(.SUPPORTED_MODES(CFG_ALL)) u_dut_all (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd[2]), .mode_o(md[2]), .asid_o(as[2]), .root_ppn_o(pp[2]), .xlat_on_o(on[2]));

    function automatic logic [15:0] cfg_of(int i);
        return (i == 0) ? CFG_DEF : (i == 1) ? CFG_BARE : CFG_ALL;
    endfunction

    // Acceptance from the requirements: bare always, 8 and 9 if enabled.
    function automatic bit accepts(int i, int m);
        logic [15:0] c;
        c = cfg_of(i);
        if (m == 0) return 1'b1;
        if (m == 8 || m == 9) return c[m];
        return 1'b0;
    endfunction

    function automatic string tag_of(int i, int m);
        if (m == 0) return (cfg_of(i)[0]) ? "R7" : "R5";
        if (m == 8 || m == 9) return accepts(i, m) ? "R3" : "R4";
        return "R6";
    endfunction

    task automatic chk64(string tag, int i, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dut%0d actual=%h expected=%h", tag, i, act, exp);
        end
    endtask

    // Compare all outputs of every instance with the bench model.
    task automatic check_all(string tag_main, bit per_mode_tag, int m);
        for (int i = 0; i < 3; i++) begin
            string t;
            t = per_mode_tag ? tag_of(i, m) : tag_main;
            chk64(t, i, rd[i], exp_q[i]);
            chk64("R2", i, {60'd0, md[i]}, {60'd0, exp_q[i][63:60]});
            chk64("R2", i, {48'd0, as[i]}, {48'd0, exp_q[i][59:44]});
            chk64("R2", i, {20'd0, pp[i]}, {20'd0, exp_q[i][43:0]});
            chk64("R8", i, {63'd0, on[i]}, {63'd0, exp_q[i][63:60] != 4'd0});
        end
    endtask

    task automatic do_write(logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        for (int i = 0; i < 3; i++)
            if (accepts(i, int'(d[63:60]))) exp_q[i] = d;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) exp_q[i] = '0;
        wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, 0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++) begin
            // Preload a paged (or, where not allowed, bare) nonzero state.
            do_write({4'd8, 16'hA5A5 ^ 16'(p), 44'h0F0_F0F0_F0F0 + 44'(p)});
            do_write({4'd9, 16'h5A5A ^ 16'(p), 44'h123_4567_89AB ^ 44'(p)});
            check_all("R3", 1'b0, 0);
            for (int m = 0; m < 16; m++) begin
                logic [15:0] a;
                logic [43:0] q;
                a = 16'h1357 ^ 16'(p * 16'h1111) ^ 16'(m);
                q = 44'hABC_DEF0_1234 + 44'(p * 44'h1_0000_0001) + 44'(m * 7);
                do_write({4'(m), a, q});
                check_all("", 1'b1, m);
            end
            // Hold: wr_en low with noise on the data bus.
            @(negedge clk);
            wr_data = {4'd9, 60'h0_DEAD_BEEF_CAFE ^ 60'(p)};
            @(negedge clk);
            wr_data = ~wr_data;
            @(negedge clk);
            check_all("R9", 1'b0, 0);
        end

        // Reset from a loaded state clears again.
        do_write({4'd8, 16'hFFFF, 44'hFFF_FFFF_FFFF});
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) exp_q[i] = '0;
        @(negedge clk);
        check_all("R1", 1'b0, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule